// File: doc/BRIEF.md
# Arbitrated atomic lock unit

A small bank of one-bit lock words shared by several requesters over a single bus. Each requester presents a request made of an operation code, a lock index and a write bit. A round-robin arbiter picks one requester per cycle. The chosen operation runs as one indivisible step against the lock bank, and the result comes back one cycle later.

The key operation is the atomic swap (test-and-set). It hands back the old lock value and stores 1 in the same step, so nothing from another requester can fall between the read and the write. A value of 0 means free and 1 means held. Software acquires a lock by swapping until it gets back 0. It spins with plain reads, which change nothing. It releases the lock by writing 0.

When many requesters swap the same free lock in the same cycle, the arbiter puts them in order. Exactly one of them sees 0.

Top module: `swap_lock_unit`

## Requirements
- R1: After a synchronous reset, `resp_valid` is all zeros and every lock word reads 0.
- R2: Operation codes on each 2-bit `req_op` field are: 0 = read, 1 = write of `req_wdata`, 2 = swap, 3 = read (alias of code 0).
- R3: A swap returns the lock word's previous value on `resp_rdata` and leaves the word at 1, both within the same granted operation.
- R4: A read returns the current lock value and does not modify it.
- R5: A write stores `req_wdata` into the word; writing 0 releases a held lock, and writing 0 to a free lock is accepted and leaves it at 0.
- R6: At most one requester is granted per cycle. The granted requester, and no other, sees its `resp_valid` bit high for exactly one cycle, on the cycle after the grant. `resp_rdata` carries that operation's result in the same cycle.
- R7: Arbitration is round robin. Search starts at the requester after the last one granted, and requester 0 has first priority after reset.
- R8: When all requesters swap the same free lock together, exactly one receives 0 and all others receive 1.
- R9: A requester whose `resp_valid` bit is high in a cycle is not eligible for a grant in that cycle. A request held high is therefore served at most every second cycle.
- R10: Operation code 3 behaves as a read: it returns the current value and leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_op | input | 2*NREQ | Operation code per requester (2 bits each) |
| req_idx | input | IW*NREQ | Lock index per requester |
| req_wdata | input | NREQ | Bit to store on a write, per requester |
| resp_valid | output | NREQ | One-cycle response pulse to the requester served last cycle |
| resp_rdata | output | 1 | Lock value before the served operation |

## Verification
A corrupted lock bit shows up at the ports on the next read or swap of that index. It appears one cycle after that operation's grant, as a wrong `resp_rdata`. An arbiter pointer in the wrong state shows up at once in the order of `resp_valid` pulses among contenders: the first pulse after a contested cycle goes to the wrong requester. A fault in the swap write-back hides until a second swap or read of the same word. The bench therefore always follows a swap with another access to the same index.

// File: rtl/swap_lock_pkg.sv
package swap_lock_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_PEEK  = 2'd3
  } lock_op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int NREQ = 4,
  localparam int GW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant,
  output logic [GW-1:0]   gidx,
  output logic            gany
);
  logic [GW-1:0] last_q;

  function automatic int slot(input logic [GW-1:0] base, input int k);
    return (int'(base) + k) % NREQ;
  endfunction

  always_comb begin
    grant = '0;
    gidx  = '0;
    gany  = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      if (!gany && req[slot(last_q, k)]) begin
        gany = 1'b1;
        gidx = GW'(slot(last_q, k));
      end
    end
    if (gany) grant[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= GW'(NREQ - 1);
    else if (gany) last_q <= gidx;
  end
endmodule

// File: rtl/lock_store.sv
module lock_store #(
  parameter int NLOCKS = 8,
  localparam int IW = (NLOCKS > 1) ? $clog2(NLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_bit,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_bit,
  output logic [NLOCKS-1:0] bits_o
);
  logic [NLOCKS-1:0] mem_q;

  assign rd_bit = mem_q[rd_idx];
  assign bits_o = mem_q;

  always_ff @(posedge clk) begin
    if (rst)        mem_q <= '0;
    else if (wr_en) mem_q[wr_idx] <= wr_bit;
  end
endmodule

// File: rtl/swap_lock_unit.sv
module swap_lock_unit #(
  parameter int NREQ   = 4,
  parameter int NLOCKS = 8,
  localparam int IW = (NLOCKS > 1) ? $clog2(NLOCKS) : 1,
  localparam int GW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [IW*NREQ-1:0] req_idx,
  input  logic [NREQ-1:0]    req_wdata,
  output logic [NREQ-1:0]    resp_valid,
  output logic               resp_rdata
);
  import swap_lock_pkg::*;

  logic [NREQ-1:0]   eligible, grant;
  logic [GW-1:0]     gidx;
  logic              gnt_any;
  lock_op_e          cur_op;
  logic [IW-1:0]     cur_idx;
  logic              cur_wd, old_bit, wr_en, wr_bit;
  logic [NLOCKS-1:0] lock_bits;
  logic [NREQ-1:0]   resp_valid_q;
  logic              resp_rdata_q;

  // a requester being answered this cycle sits out this cycle
  assign eligible = req_valid & ~resp_valid_q;

  rr_arbiter #(.NREQ(NREQ)) arb_i (
    .clk(clk), .rst(rst), .req(eligible),
    .grant(grant), .gidx(gidx), .gany(gnt_any)
  );

  assign cur_op  = lock_op_e'(req_op[gidx*2 +: 2]);
  assign cur_idx = req_idx[gidx*IW +: IW];
  assign cur_wd  = req_wdata[gidx];

  always_comb begin
    wr_en  = 1'b0;
    wr_bit = 1'b0;
    if (gnt_any) begin
      unique case (cur_op)
        OP_WRITE: begin wr_en = 1'b1; wr_bit = cur_wd; end
        OP_SWAP:  begin wr_en = 1'b1; wr_bit = 1'b1;   end
        default:  begin wr_en = 1'b0; wr_bit = 1'b0;   end
      endcase
    end
  end

  lock_store #(.NLOCKS(NLOCKS)) store_i (
    .clk(clk), .rst(rst),
    .rd_idx(cur_idx), .rd_bit(old_bit),
    .wr_en(wr_en), .wr_idx(cur_idx), .wr_bit(wr_bit),
    .bits_o(lock_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_q <= '0;
      resp_rdata_q <= 1'b0;
    end else begin
      resp_valid_q <= grant;
      if (gnt_any) resp_rdata_q <= old_bit;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_rdata_q;
endmodule

// File: rtl/swap_lock_unit_chk.sv
module swap_lock_unit_chk #(
  parameter int NREQ   = 4,
  parameter int NLOCKS = 8,
  localparam int IW = (NLOCKS > 1) ? $clog2(NLOCKS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NREQ-1:0]   req_valid,
  input logic [NREQ-1:0]   resp_valid,
  input logic              resp_rdata,
  input logic              gany,
  input logic [1:0]        cur_op,
  input logic [IW-1:0]     cur_idx,
  input logic              cur_wd,
  input logic [NLOCKS-1:0] lock_bits
);
  // R6
  one_resp_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(resp_valid));

  // R3
  swap_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (gany && cur_op == 2'd2) |=> lock_bits[$past(cur_idx)]);

  // R3
  swap_old_chk: assert property (@(posedge clk) disable iff (rst)
    (gany && cur_op == 2'd2) |=> resp_rdata == $past(lock_bits[cur_idx]));

  // R4
  read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (gany && (cur_op == 2'd0 || cur_op == 2'd3)) |=> $stable(lock_bits));

  // R5
  write_val_chk: assert property (@(posedge clk) disable iff (rst)
    (gany && cur_op == 2'd1) |=> lock_bits[$past(cur_idx)] == $past(cur_wd));

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    // R6
    resp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
      resp_valid[i] |-> $past(req_valid[i]));
    // R9
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      resp_valid[i] |=> !resp_valid[i]);
  end
endmodule

bind swap_lock_unit swap_lock_unit_chk #(.NREQ(NREQ), .NLOCKS(NLOCKS)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .resp_valid(resp_valid),
  .resp_rdata(resp_rdata), .gany(gnt_any), .cur_op(cur_op),
  .cur_idx(cur_idx), .cur_wd(cur_wd), .lock_bits(lock_bits)
);

// File: tb/swap_lock_unit_test.sv
module swap_lock_unit_test;
  localparam int NREQ = 4;
  localparam int NLOCKS = 8;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  logic [NREQ-1:0]    req_valid = '0;
  logic [2*NREQ-1:0]  req_op = '0;
  logic [IW*NREQ-1:0] req_idx = '0;
  logic [NREQ-1:0]    req_wdata = '0;
  logic [NREQ-1:0]    resp_valid;
  logic               resp_rdata;

  int checks = 0, errors = 0;
  int rr_last = NREQ - 1;
  logic model [NLOCKS];

  always #10 clk = ~clk;

  swap_lock_unit #(.NREQ(NREQ), .NLOCKS(NLOCKS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int next_rr(input int last, input logic [NREQ-1:0] pend);
    for (int k = 1; k <= NREQ; k++)
      if (pend[(last + k) % NREQ]) return (last + k) % NREQ;
    return -1;
  endfunction

  // every requester in mask issues the same op on the same index at once
  task automatic run_group(input logic [NREQ-1:0] mask, input logic [1:0] op,
                           input int idx, input logic wd, input string tag,
                           output int zeros);
    logic [NREQ-1:0] pend = mask;
    zeros = 0;
    @(negedge clk);
    for (int r = 0; r < NREQ; r++) if (mask[r]) begin
      req_op[r*2 +: 2] = op;
      req_idx[r*IW +: IW] = IW'(idx);
      req_wdata[r] = wd;
    end
    req_valid = mask;
    while (pend != 0) begin
      int w;
      logic exp_d;
      w = next_rr(rr_last, pend);
      exp_d = model[idx];
      if (op == 2'd1) model[idx] = wd;
      else if (op == 2'd2) model[idx] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check({tag, " grant"}, int'(resp_valid), 1 << w);
      check({tag, " data"}, int'(resp_rdata), int'(exp_d));
      if (resp_rdata == 1'b0) zeros++;
      pend[w] = 1'b0;
      req_valid[w] = 1'b0;
      rr_last = w;
    end
    @(negedge clk);
    check({tag, " R6 pulse ends"}, int'(resp_valid), 0);
  endtask

  task automatic t_reset();
    int z;
    check("R1 resp_valid", int'(resp_valid), 0);
    for (int i = 0; i < NLOCKS; i++) run_group(4'b0001, 2'd0, i, 1'b0, "R1 read", z);
  endtask

  task automatic t_swap_read();
    int z;
    run_group(4'b0010, 2'd2, 2, 1'b0, "R3 swap free", z);
    check("R3 first swap sees 0", z, 1);
    run_group(4'b1000, 2'd2, 2, 1'b0, "R3 swap held", z);
    check("R3 second swap sees 1", z, 0);
    run_group(4'b0001, 2'd0, 2, 1'b0, "R4 read", z);
    run_group(4'b0001, 2'd0, 2, 1'b0, "R4 reread", z);
    run_group(4'b0100, 2'd3, 2, 1'b0, "R10 peek", z);
    run_group(4'b0100, 2'd0, 2, 1'b0, "R10 after peek", z);
  endtask

  task automatic t_write();
    int z;
    run_group(4'b0100, 2'd1, 2, 1'b0, "R5 release", z);
    run_group(4'b0001, 2'd0, 2, 1'b0, "R5 read freed", z);
    run_group(4'b0100, 2'd1, 2, 1'b0, "R5 release free", z);
    run_group(4'b0010, 2'd0, 2, 1'b0, "R5 still free", z);
    run_group(4'b1000, 2'd1, 7, 1'b1, "R2 write one", z);
    run_group(4'b0001, 2'd0, 7, 1'b0, "R2 read one", z);
    run_group(4'b1000, 2'd1, 7, 1'b0, "R5 release 7", z);
  endtask

  task automatic t_contend();
    int z;
    run_group(4'b1111, 2'd2, 5, 1'b0, "R8 contend", z);
    check("R8 single winner", z, 1);
    run_group(4'b0101, 2'd0, 5, 1'b0, "R7 rr pair", z);
    run_group(4'b1010, 2'd0, 0, 1'b0, "R7 rr pair b", z);
  endtask

  task automatic t_hold();
    @(negedge clk);
    req_op[2 +: 2] = 2'd0;
    req_idx[IW +: IW] = 3'd5;
    req_valid = 4'b0010;
    @(posedge clk); @(negedge clk);
    check("R9 first serve", int'(resp_valid), 2);
    check("R9 first data", int'(resp_rdata), 1);
    @(posedge clk); @(negedge clk);
    check("R9 masked cycle", int'(resp_valid), 0);
    @(posedge clk); @(negedge clk);
    check("R9 served again", int'(resp_valid), 2);
    req_valid = '0;
    rr_last = 1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NLOCKS; i++) model[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_swap_read();
    t_write();
    t_contend();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule